// File: doc/BRIEF.md
# Decimation Phase Synchronizer

This block keeps the decimation phase of a three-stage decimating receiver chain aligned across several identical devices. It holds one phase counter for each stage: a first integrator-comb stage that decimates by Ma, a second integrator-comb stage that decimates by Mb, and a decimating FIR stage that decimates by Mf. Each counter advances only when its upstream stage produces a sample. From these counters the block issues one enable per stage, marking the sample on which that stage emits its output.

Two synchronization pulses travel between devices over shared bidirectional pads. The integrator-comb pulse marks the last sample of every Ma×Mb period. The FIR pulse marks the last sample of every Ma×Mb×Mf period, so it always lands on an integrator-comb pulse. A device set as master drives both pulses onto its pads. A device set as slave leaves its pad drivers off. Either way, the block realigns on the pad values it reads back, so a master follows its own looped-back pulse exactly as a slave follows the external one. When no pulse arrives, the counters keep running on their own.

Top module: `dec_phase_sync`

## Requirements
- R1: While `rst` is high, all three stage enables are low. In the first cycle after `rst` falls, every stage sits at phase 0, and its decimation factor is the one presented on its factor input during reset.
- R2: `cic_a_en_o` is high on valid sample n (counted from phase 0) exactly when n mod Ma = Ma−1.
- R3: `cic_b_en_o` is high on valid sample n exactly when n mod (Ma·Mb) = Ma·Mb−1. It is never high without `cic_a_en_o`.
- R4: `fir_en_o` is high on valid sample n exactly when n mod (Ma·Mb·Mf) = Ma·Mb·Mf−1. It is never high without `cic_b_en_o`.
- R5: With every cycle valid, a master holds `pad_cic_o` high in exactly the cycles in which `cic_b_en_o` is high, and `pad_fir_o` high in exactly the cycles in which `fir_en_o` is high. `pad_fir_o` is never high without `pad_cic_o`.
- R6: `pad_oe_o` is 1 when `master_i` is 1 and 0 when it is 0. In slave mode the enables follow the external values on `pad_cic_i` and `pad_fir_i`.
- R7: A 1 on `pad_cic_i` in a valid cycle makes that cycle the final sample of both integrator-comb periods, so `cic_a_en_o` and `cic_b_en_o` are high in that cycle. A 1 on `pad_fir_i` does the same for the FIR stage.
- R8: With no pulse on either pad input, the enables repeat at their periods indefinitely.
- R9: Counters advance only on cycles with `sample_valid_i` high, and no enable is ever high in a cycle where it is low.
- R10: A pulse that arrives in a cycle with no valid sample leaves the stage at its final position, so the next valid sample raises the enables.
- R11: Factors range from 1 to 32. A change on a factor input takes effect only at reset or at the next pulse for that stage: `pad_cic_i` for both integrator-comb stages, `pad_fir_i` for the FIR stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1 = master (drive pads), 0 = slave |
| dec_cic_a_i | input | FW | First integrator-comb decimation factor Ma |
| dec_cic_b_i | input | FW | Second integrator-comb decimation factor Mb |
| dec_fir_i | input | FW | FIR decimation factor Mf |
| sample_valid_i | input | 1 | Input sample present this cycle |
| pad_cic_i | input | 1 | Integrator-comb pulse as read from the pad |
| pad_fir_i | input | 1 | FIR pulse as read from the pad |
| pad_cic_o | output | 1 | Integrator-comb pulse pad drive (registered) |
| pad_fir_o | output | 1 | FIR pulse pad drive (registered) |
| pad_oe_o | output | 1 | Pad driver enable |
| cic_a_en_o | output | 1 | First integrator-comb output enable |
| cic_b_en_o | output | 1 | Second integrator-comb output enable |
| fir_en_o | output | 1 | FIR output enable |

## Verification
The bench builds the block with the default six-bit factor width, so every factor from 1 to 32 can be used. It runs masters with factor sets (3,1,3), (2,3,2), (1,1,4) and (1,1,32). These cover the unity-factor case, where the pulse is already high in the first cycle after reset, and the largest FIR period. The bench models the pads as a loopback gated by `pad_oe_o`. This lets it realign a slave in mid-period, stall it with gaps in the valid strobe, send it a pulse in a cycle with no valid sample, and change a factor between two master pulses.

// File: rtl/dps_pkg.sv
package dps_pkg;
    // Width of decimation factor inputs; factors 1..32 fit with headroom.
    parameter int FAC_W  = 6;
    // Stage order along the chain; the last stage follows the FIR pad.
    parameter int NSTAGE = 3;

    typedef enum logic [1:0] {
        STG_CIC_A = 2'd0,
        STG_CIC_B = 2'd1,
        STG_FIR   = 2'd2
    } stage_e;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } sync_role_e;

    typedef struct packed {
        logic cic;
        logic fir;
    } pulse_pair_t;

    function automatic sync_role_e role_of(input logic mode_bit);
        return mode_bit ? ROLE_MASTER : ROLE_SLAVE;
    endfunction
endpackage

// File: rtl/dps_stage.sv
module dps_stage #(
    parameter int W = dps_pkg::FAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] fac_i,
    input  logic         sync_i,
    input  logic         adv_i,
    output logic         fire_o,
    output logic         next_last_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q, fac_q;
    logic [W-1:0] last, eff, nxt, nxt_c, fac_nxt;

    // A pulse marks the current cycle as the final position of the period.
    assign last    = fac_q - ONE;
    assign eff     = sync_i ? last : cnt_q;
    assign fire_o  = adv_i && (eff == last);
    assign fac_nxt = (rst || sync_i) ? fac_i : fac_q;

    always_comb begin
        if (!adv_i)
            nxt = sync_i ? (fac_i - ONE) : cnt_q;
        else if (eff == last)
            nxt = '0;
        else
            nxt = eff + ONE;
    end

    assign nxt_c       = rst ? '0 : nxt;
    assign next_last_o = (nxt_c == (fac_nxt - ONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            fac_q <= fac_i;
        end else begin
            cnt_q <= nxt;
            fac_q <= fac_nxt;
        end
    end

    // R8: the phase never leaves its period
    a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q < fac_q);
    // R7: an accepted pulse on a sample restarts the stage at phase 0
    a_r7_sync_restart: assert property (@(posedge clk) disable iff (rst)
        (sync_i && adv_i) |=> (cnt_q == '0));
    // R10: a pulse without a sample parks the stage on its final position
    a_r10_sync_park: assert property (@(posedge clk) disable iff (rst)
        (sync_i && !adv_i) |=> (cnt_q == fac_q - ONE));
    // R11: the active factor moves only on a pulse
    a_r11_fac_hold: assert property (@(posedge clk) disable iff (rst)
        !sync_i |=> $stable(fac_q));
endmodule

// File: rtl/dps_pad_drv.sv
module dps_pad_drv
    import dps_pkg::*;
#(
    parameter int NS = dps_pkg::NSTAGE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_i,
    input  logic [NS-1:0] next_last_i,
    output logic          pad_cic_o,
    output logic          pad_fir_o,
    output logic          pad_oe_o
);
    pulse_pair_t pend, pulse_q;

    // Look one cycle ahead so the registered pulse lines up with the final sample.
    assign pend.cic = &next_last_i[NS-2:0];
    assign pend.fir = &next_last_i;

    always_ff @(posedge clk) begin
        pulse_q <= pend;
    end

    assign pad_cic_o = pulse_q.cic;
    assign pad_fir_o = pulse_q.fir;
    assign pad_oe_o  = (role_of(mode_i) == ROLE_MASTER);

    // R5: the FIR pulse only rides on an integrator-comb pulse
    a_r5_fir_on_cic: assert property (@(posedge clk) disable iff (rst)
        pad_fir_o |-> pad_cic_o);
endmodule

// File: rtl/dec_phase_sync.sv
module dec_phase_sync
    import dps_pkg::*;
#(
    parameter int FW = dps_pkg::FAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          master_i,
    input  logic [FW-1:0] dec_cic_a_i,
    input  logic [FW-1:0] dec_cic_b_i,
    input  logic [FW-1:0] dec_fir_i,
    input  logic          sample_valid_i,
    input  logic          pad_cic_i,
    input  logic          pad_fir_i,
    output logic          pad_cic_o,
    output logic          pad_fir_o,
    output logic          pad_oe_o,
    output logic          cic_a_en_o,
    output logic          cic_b_en_o,
    output logic          fir_en_o
);
    localparam int NS = NSTAGE;

    logic [FW-1:0] fac [NS];
    logic [NS-1:0] adv, fire, nlast, sync_v;

    assign fac[STG_CIC_A] = dec_cic_a_i;
    assign fac[STG_CIC_B] = dec_cic_b_i;
    assign fac[STG_FIR]   = dec_fir_i;

    genvar i;
    generate
        for (i = 0; i < NS; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign adv[i] = sample_valid_i && !rst;
            end else begin : g_link
                assign adv[i] = fire[i-1];
            end
            if (i == NS - 1) begin : g_fir_sync
                assign sync_v[i] = pad_fir_i;
            end else begin : g_cic_sync
                assign sync_v[i] = pad_cic_i;
            end
            dps_stage #(.W(FW)) u_stg (
                .clk         (clk),
                .rst         (rst),
                .fac_i       (fac[i]),
                .sync_i      (sync_v[i]),
                .adv_i       (adv[i]),
                .fire_o      (fire[i]),
                .next_last_o (nlast[i])
            );
        end
    endgenerate

    assign cic_a_en_o = fire[STG_CIC_A];
    assign cic_b_en_o = fire[STG_CIC_B];
    assign fir_en_o   = fire[STG_FIR];

    dps_pad_drv #(.NS(NS)) u_pad (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (master_i),
        .next_last_i (nlast),
        .pad_cic_o   (pad_cic_o),
        .pad_fir_o   (pad_fir_o),
        .pad_oe_o    (pad_oe_o)
    );

    // R1: enables stay quiet in reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |-> !(cic_a_en_o || cic_b_en_o || fir_en_o));
    // R3: second integrator-comb enable implies the first
    a_r3_b_needs_a: assert property (@(posedge clk) disable iff (rst)
        cic_b_en_o |-> cic_a_en_o);
    // R4: FIR enable implies the second integrator-comb enable
    a_r4_fir_needs_b: assert property (@(posedge clk) disable iff (rst)
        fir_en_o |-> cic_b_en_o);
    // R9: no enable without a sample
    a_r9_en_needs_valid: assert property (@(posedge clk) disable iff (rst)
        cic_a_en_o |-> sample_valid_i);
endmodule

// File: tb/sim_dec_phase_sync.sv
module sim_dec_phase_sync;
    localparam int FW = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, master = 1'b1, valid = 1'b1;
    logic [FW-1:0] fa = FW'(3), fb = FW'(1), ff = FW'(3);
    logic ext_cic = 1'b0, ext_fir = 1'b0;
    logic pad_cic_i, pad_fir_i, pad_cic_o, pad_fir_o, pad_oe_o;
    logic cic_a_en, cic_b_en, fir_en;

    // Bidirectional pad model: the driven value wins when enabled.
    assign pad_cic_i = pad_oe_o ? pad_cic_o : ext_cic;
    assign pad_fir_i = pad_oe_o ? pad_fir_o : ext_fir;

    dec_phase_sync #(.FW(FW)) u0 (
        .clk(clk), .rst(rst), .master_i(master),
        .dec_cic_a_i(fa), .dec_cic_b_i(fb), .dec_fir_i(ff),
        .sample_valid_i(valid), .pad_cic_i(pad_cic_i), .pad_fir_i(pad_fir_i),
        .pad_cic_o(pad_cic_o), .pad_fir_o(pad_fir_o), .pad_oe_o(pad_oe_o),
        .cic_a_en_o(cic_a_en), .cic_b_en_o(cic_b_en), .fir_en_o(fir_en)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input int k,
                       input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d actual=%0b expected=%0b", req, what, k, act, exp);
        end
    endtask

    // Leaves the bench one time step into cycle 0 after reset release.
    task automatic do_reset(input logic m, input int a, input int b, input int f);
        rst = 1'b1; master = m; valid = 1'b1; ext_cic = 1'b0; ext_fir = 1'b0;
        fa = FW'(a); fb = FW'(b); ff = FW'(f);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b1, 3, 1, 3);
        rst = 1'b1;
        @(posedge clk); #2;
        chk("R1", "cic_a_en in reset", -1, cic_a_en, 1'b0);
        chk("R1", "fir_en in reset", -1, fir_en, 1'b0);
        chk("R1", "pad_cic_o in reset", -1, pad_cic_o, 1'b0);
    endtask

    task automatic run_master(input int a, input int b, input int f, input int n);
        int pa, pb, pf;
        pa = a; pb = a * b; pf = a * b * f;
        do_reset(1'b1, a, b, f);
        for (int k = 0; k < n; k++) begin
            #1;
            chk("R2", "cic_a_en", k, cic_a_en, (k % pa) == pa - 1);
            chk("R3", "cic_b_en", k, cic_b_en, (k % pb) == pb - 1);
            chk("R4", "fir_en", k, fir_en, (k % pf) == pf - 1);
            chk("R5", "pad_cic_o", k, pad_cic_o, (k % pb) == pb - 1);
            chk("R5", "pad_fir_o", k, pad_fir_o, (k % pf) == pf - 1);
            chk("R6", "pad_oe_o master", k, pad_oe_o, 1'b1);
            @(posedge clk); #1;
        end
    endtask

    // Slave free-runs, then realigns on an external pulse at cycle 5.
    task automatic t_slave_realign();
        do_reset(1'b0, 4, 1, 2);
        for (int k = 0; k < 30; k++) begin
            logic ea, ef;
            ext_cic = (k == 5); ext_fir = (k == 5);
            if (k < 5) begin ea = (k % 4) == 3; ef = (k % 8) == 7; end
            else begin ea = ((k - 5) % 4) == 0; ef = ((k - 5) % 8) == 0; end
            #1;
            chk("R6", "pad_oe_o slave", k, pad_oe_o, 1'b0);
            chk(k < 5 ? "R8" : "R7", "cic_a_en", k, cic_a_en, ea);
            chk("R7", "cic_b_en", k, cic_b_en, ea);
            chk("R7", "fir_en", k, fir_en, ef);
            @(posedge clk); #1;
        end
        ext_cic = 1'b0; ext_fir = 1'b0;
    endtask

    // Gaps in the valid strobe hold the phase.
    task automatic t_stall();
        int nv = 0;
        do_reset(1'b0, 3, 1, 1);
        for (int k = 0; k < 30; k++) begin
            logic e;
            valid = (k % 3) != 1;
            e = valid && (nv % 3) == 2;
            #1;
            chk("R9", "cic_a_en stall", k, cic_a_en, e);
            chk("R9", "fir_en stall", k, fir_en, e);
            if (valid) nv++;
            @(posedge clk); #1;
        end
        valid = 1'b1;
    endtask

    // Pulse arrives with no sample; next sample fires.
    task automatic t_sync_no_valid();
        do_reset(1'b0, 3, 1, 1);
        for (int k = 0; k < 14; k++) begin
            logic e;
            valid = (k != 4); ext_cic = (k == 4); ext_fir = (k == 4);
            e = (k < 4) ? (k == 2) : (k >= 5 && ((k - 5) % 3) == 0);
            #1;
            chk("R10", "cic_b_en", k, cic_b_en, e);
            chk("R10", "fir_en", k, fir_en, e);
            @(posedge clk); #1;
        end
        valid = 1'b1; ext_cic = 1'b0; ext_fir = 1'b0;
    endtask

    // Factor change waits for the next pulse.
    task automatic t_factor_change();
        do_reset(1'b1, 2, 1, 1);
        for (int k = 0; k < 16; k++) begin
            logic e;
            if (k == 2) fa = FW'(4);
            e = (k == 1) || (k == 3) || (k >= 7 && ((k - 7) % 4) == 0);
            #1;
            chk("R11", "pad_cic_o", k, pad_cic_o, e);
            chk("R11", "cic_a_en", k, cic_a_en, e);
            @(posedge clk); #1;
        end
    endtask

    initial begin
        t_reset();
        run_master(3, 1, 3, 27);
        run_master(2, 3, 2, 40);
        run_master(1, 1, 4, 12);
        run_master(1, 1, 32, 70);
        t_slave_realign();
        t_stall();
        t_sync_no_valid();
        t_factor_change();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog run did not complete actual=hung expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule